// File: doc/BRIEF.md
# In-Order Dual-Issue Scheduler

This block is the issue point of an in-order pipeline that has two execution paths: one for memory operations (loads and stores) and one for register arithmetic. Decoded operations come in through a push port, one per cycle, into a small internal queue. Each cycle the scheduler looks at the two oldest queued operations and sends zero, one or both of them into execution. An operation issues when the operation is released from register read into the first execute stage.

A countdown per architectural register tracks when each result becomes usable. When an operation issues, the countdown of its destination is loaded from the producer's class. A load's consumer may issue three cycles after the load at the earliest, and an arithmetic result is usable two cycles after its producer issued. The memory path is fully pipelined, so memory operations can issue on consecutive cycles without limit. The block drives one strobe for each path, a stall flag and a free-running cycle counter, and it holds the counter value of the most recent issue. When the queue drains, that value is the issue cycle of the last operation.

Top module: `dual_issue_sched`

## Requirements
- R1: While reset is low, and after it is released, the queue is empty (`empty`=1, `full`=0), neither strobe nor `stall` is set, and `cyc_cnt` and `last_fire_cyc` are zero.
- R2: Operations issue strictly in program order. When the oldest queued operation cannot issue, the one behind it is held as well, even if that one is ready.
- R3: In one cycle at most one memory operation and at most one arithmetic operation issue. When the two oldest operations have the same path, only the older one issues.
- R4: An operation that reads a register written by a load (class 1) issues no earlier than 3 cycles after the load issued.
- R5: An operation that reads a register written by an arithmetic operation (class 0, or the spare code 3, which is treated as arithmetic) issues no earlier than 2 cycles after its producer issued.
- R6: The younger of the two head operations does not issue in the same cycle as the older one if it reads the older one's destination.
- R7: A load reads only its address register `push_sa`, and its `push_sb` field has no effect. A store (class 2) reads the address `push_sa` and the data `push_sb`, writes no register, and its `push_dst` field has no effect.
- R8: `stall` is 1 exactly when the queue holds at least one operation and nothing issues in that cycle.
- R9: `cyc_cnt` rises by one each cycle after reset. `last_fire_cyc` takes the `cyc_cnt` value of every cycle in which a strobe is set. `empty` is 1 once every pushed operation has issued.
- R10: A push is accepted only while `full` is 0. A push presented while the queue holds DEPTH operations is dropped and never issues.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| push | input | 1 | Offer one decoded operation to the queue |
| push_cls | input | 2 | Class: 0 arithmetic, 1 load, 2 store, 3 treated as arithmetic |
| push_dst | input | 5 | Destination register |
| push_sa | input | 5 | First source register (address for memory operations) |
| push_sb | input | 5 | Second source register (store data, second operand for arithmetic) |
| full | output | 1 | Queue holds DEPTH operations, so a push is ignored |
| empty | output | 1 | Queue holds no operation |
| mem_fire | output | 1 | A memory operation issues this cycle |
| alu_fire | output | 1 | An arithmetic operation issues this cycle |
| stall | output | 1 | The queue is non-empty and nothing issues |
| cyc_cnt | output | 16 | Cycles since reset |
| last_fire_cyc | output | 16 | `cyc_cnt` value of the latest issue cycle |

## Verification
A countdown that is loaded with the wrong value, or that is never loaded, moves a dependent operation's strobe earlier or later. That error shows at the ports within three cycles of the producer's strobe. A queue pointer or fill count that goes wrong shows up as a missing, repeated or extra strobe before the queue drains, or as `empty` or `full` at the wrong time. Each scenario therefore compares both strobes and `stall` on every cycle from the first push until the queue drains, and after that it checks `empty` and the recorded last issue cycle.

// File: rtl/sched_pkg.sv
package sched_pkg;

  localparam int REG_AW = 5;
  localparam int NREG   = 1 << REG_AW;

  typedef enum logic [1:0] {
    CL_ARITH = 2'd0,
    CL_LOAD  = 2'd1,
    CL_STORE = 2'd2,
    CL_SPARE = 2'd3
  } iclass_e;

  typedef struct packed {
    iclass_e           cls;
    logic [REG_AW-1:0] dst;
    logic [REG_AW-1:0] sa;
    logic [REG_AW-1:0] sb;
  } uop_t;

  function automatic logic is_mem(iclass_e c);
    return (c == CL_LOAD) || (c == CL_STORE);
  endfunction

  function automatic logic reads_b(iclass_e c);
    return c != CL_LOAD;
  endfunction

  function automatic logic writes_dst(iclass_e c);
    return c != CL_STORE;
  endfunction

endpackage

// File: rtl/sched_q.sv
module sched_q
  import sched_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  uop_t          din,
  input  logic [1:0]    pop_n,
  output uop_t          head0,
  output uop_t          head1,
  output logic [CW-1:0] fill,
  output logic          full
);

  uop_t          slot_q [DEPTH];
  logic [AW-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [CW-1:0] fill_d;
  logic          acc;

  assign full  = (fill == CW'(DEPTH));
  assign acc   = push && !full;
  assign head0 = slot_q[rd_q];
  assign head1 = slot_q[rd_q + AW'(1)];

  always_comb begin
    wr_d   = acc ? wr_q + AW'(1) : wr_q;
    rd_d   = rd_q + AW'(pop_n);
    fill_d = fill + CW'(acc) - CW'(pop_n);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q <= '0;
      rd_q <= '0;
      fill <= '0;
    end else begin
      wr_q <= wr_d;
      rd_q <= rd_d;
      fill <= fill_d;
    end
  end

  always_ff @(posedge clk) begin
    if (acc) slot_q[wr_q] <= din;
  end

  // R2
  pop_within_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    CW'(pop_n) <= fill);

  // R10
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= CW'(DEPTH));

endmodule

// File: rtl/sched_sb.sv
module sched_sb
  import sched_pkg::*;
#(
  parameter int CDW = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  we_o,
  input  logic [REG_AW-1:0]     dst_o,
  input  logic [CDW-1:0]        ld_o,
  input  logic                  we_y,
  input  logic [REG_AW-1:0]     dst_y,
  input  logic [CDW-1:0]        ld_y,
  input  logic [3:0][REG_AW-1:0] rd_a,
  output logic [3:0]            rd_busy
);

  logic [CDW-1:0] cnt_q [NREG];
  logic [CDW-1:0] cnt_d [NREG];

  always_comb begin
    for (int r = 0; r < NREG; r++) begin
      if (we_y && dst_y == REG_AW'(r))      cnt_d[r] = ld_y;
      else if (we_o && dst_o == REG_AW'(r)) cnt_d[r] = ld_o;
      else if (cnt_q[r] != '0)              cnt_d[r] = cnt_q[r] - CDW'(1);
      else                                  cnt_d[r] = cnt_q[r];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < NREG; r++) cnt_q[r] <= '0;
    end else begin
      for (int r = 0; r < NREG; r++) cnt_q[r] <= cnt_d[r];
    end
  end

  always_comb begin
    for (int k = 0; k < 4; k++) rd_busy[k] = (cnt_q[rd_a[k]] != '0);
  end

endmodule

// File: rtl/sched_pick.sv
module sched_pick
  import sched_pkg::*;
#(
  parameter int CW     = 4,
  parameter int CDW    = 2,
  parameter int LD_LAT = 3,
  parameter int AR_LAT = 2
) (
  input  uop_t           h0,
  input  uop_t           h1,
  input  logic [CW-1:0]  fill,
  input  logic [3:0]     busy,
  output logic           iss0,
  output logic           iss1,
  output logic [1:0]     pop_n,
  output logic           mem_fire,
  output logic           alu_fire,
  output logic           we_o,
  output logic           we_y,
  output logic [CDW-1:0] ld_o,
  output logic [CDW-1:0] ld_y
);

  function automatic logic [CDW-1:0] wait_of(iclass_e c);
    return (c == CL_LOAD) ? CDW'(LD_LAT - 1) : CDW'(AR_LAT - 1);
  endfunction

  logic ok0, src1_ok, raw01, split;

  always_comb begin
    ok0     = (fill != '0) && !busy[0] && !(reads_b(h0.cls) && busy[1]);
    src1_ok = !busy[2] && !(reads_b(h1.cls) && busy[3]);
    raw01   = writes_dst(h0.cls) &&
              ((h0.dst == h1.sa) || (reads_b(h1.cls) && (h0.dst == h1.sb)));
    split   = is_mem(h0.cls) != is_mem(h1.cls);

    iss0  = ok0;
    iss1  = ok0 && (fill >= CW'(2)) && split && src1_ok && !raw01;
    pop_n = {1'b0, iss0} + {1'b0, iss1};

    mem_fire = (iss0 && is_mem(h0.cls)) || (iss1 && is_mem(h1.cls));
    alu_fire = (iss0 && !is_mem(h0.cls)) || (iss1 && !is_mem(h1.cls));

    we_o = iss0 && writes_dst(h0.cls);
    we_y = iss1 && writes_dst(h1.cls);
    ld_o = wait_of(h0.cls);
    ld_y = wait_of(h1.cls);
  end

endmodule

// File: rtl/dual_issue_sched.sv
module dual_issue_sched
  import sched_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int CYC_W  = 16,
  parameter int LD_LAT = 3,
  parameter int AR_LAT = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [1:0]        push_cls,
  input  logic [REG_AW-1:0] push_dst,
  input  logic [REG_AW-1:0] push_sa,
  input  logic [REG_AW-1:0] push_sb,
  output logic              full,
  output logic              empty,
  output logic              mem_fire,
  output logic              alu_fire,
  output logic              stall,
  output logic [CYC_W-1:0]  cyc_cnt,
  output logic [CYC_W-1:0]  last_fire_cyc
);

  localparam int CW   = $clog2(DEPTH + 1);
  localparam int MAXL = (LD_LAT > AR_LAT) ? LD_LAT : AR_LAT;
  localparam int CDW  = (MAXL > 2) ? $clog2(MAXL) : 1;

  uop_t           din, h0, h1;
  logic [CW-1:0]  fill;
  logic [1:0]     pop_n;
  logic           iss0, iss1, we_o, we_y;
  logic [CDW-1:0] ld_o, ld_y;
  logic [3:0]     busy;
  logic [3:0][REG_AW-1:0] rd_a;
  logic [CYC_W-1:0] cyc_d, last_d;
  logic           any_fire;

  assign din  = '{cls: iclass_e'(push_cls), dst: push_dst, sa: push_sa, sb: push_sb};
  assign rd_a = {h1.sb, h1.sa, h0.sb, h0.sa};

  sched_q #(.DEPTH(DEPTH)) u_q (
    .clk(clk), .rst_n(rst_n), .push(push), .din(din), .pop_n(pop_n),
    .head0(h0), .head1(h1), .fill(fill), .full(full)
  );

  sched_sb #(.CDW(CDW)) u_sb (
    .clk(clk), .rst_n(rst_n),
    .we_o(we_o), .dst_o(h0.dst), .ld_o(ld_o),
    .we_y(we_y), .dst_y(h1.dst), .ld_y(ld_y),
    .rd_a(rd_a), .rd_busy(busy)
  );

  sched_pick #(.CW(CW), .CDW(CDW), .LD_LAT(LD_LAT), .AR_LAT(AR_LAT)) u_pick (
    .h0(h0), .h1(h1), .fill(fill), .busy(busy),
    .iss0(iss0), .iss1(iss1), .pop_n(pop_n),
    .mem_fire(mem_fire), .alu_fire(alu_fire),
    .we_o(we_o), .we_y(we_y), .ld_o(ld_o), .ld_y(ld_y)
  );

  assign empty    = (fill == '0);
  assign stall    = !empty && !iss0;
  assign any_fire = mem_fire || alu_fire;

  always_comb begin
    cyc_d  = cyc_cnt + CYC_W'(1);
    last_d = any_fire ? cyc_cnt : last_fire_cyc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc_cnt       <= '0;
      last_fire_cyc <= '0;
    end else begin
      cyc_cnt       <= cyc_d;
      last_fire_cyc <= last_d;
    end
  end

  // R3
  pair_needs_two_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_fire && alu_fire) |-> (fill >= CW'(2)));

  // R4, R5
  oldest_src_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    any_fire |-> !busy[0]);

  // R8
  stall_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> !any_fire);

  // R9
  cycle_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (cyc_cnt == $past(cyc_cnt) + CYC_W'(1)));

endmodule

// File: tb/sim_dual_issue_sched.sv
`timescale 1ns/1ps
module sim_dual_issue_sched;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        push;
  logic [1:0]  push_cls;
  logic [4:0]  push_dst, push_sa, push_sb;
  logic        full, empty, mem_fire, alu_fire, stall;
  logic [15:0] cyc_cnt, last_fire_cyc;

  int n_tests = 0;
  int n_fail  = 0;

  logic [1:0] p_cls [16];
  logic [4:0] p_dst [16], p_sa [16], p_sb [16];
  logic       e_mem [16], e_alu [16], obs_full [16];
  logic [15:0] obs_cyc [16];

  always #4 clk = ~clk;

  dual_issue_sched #(.DEPTH(4)) u0 (
    .clk(clk), .rst_n(rst_n), .push(push), .push_cls(push_cls),
    .push_dst(push_dst), .push_sa(push_sa), .push_sb(push_sb),
    .full(full), .empty(empty), .mem_fire(mem_fire), .alu_fire(alu_fire),
    .stall(stall), .cyc_cnt(cyc_cnt), .last_fire_cyc(last_fire_cyc)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic set_ins(input int i, input logic [1:0] c, input logic [4:0] d,
                         input logic [4:0] a, input logic [4:0] b);
    p_cls[i] = c; p_dst[i] = d; p_sa[i] = a; p_sb[i] = b;
  endtask

  task automatic clear_exp();
    for (int s = 0; s < 16; s++) begin
      e_mem[s] = 1'b0; e_alu[s] = 1'b0;
    end
  endtask

  task automatic drive(input int i);
    push = 1'b1; push_cls = p_cls[i]; push_dst = p_dst[i];
    push_sa = p_sa[i]; push_sb = p_sb[i];
  endtask

  task automatic do_reset();
    @(negedge clk);
    push = 1'b0; rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // Pushes one operation per cycle and compares strobes and stall on each slot.
  task automatic run_prog(input int n_ins, input int n_slots, input string req);
    drive(0);
    for (int s = 1; s <= n_slots; s++) begin
      @(negedge clk);
      obs_cyc[s]  = cyc_cnt;
      obs_full[s] = full;
      chk({stall, alu_fire, mem_fire} ==
            {!(e_mem[s] || e_alu[s]), e_alu[s], e_mem[s]},
          req, $sformatf("slot %0d {stall,alu,mem}", s),
          int'({stall, alu_fire, mem_fire}),
          int'({!(e_mem[s] || e_alu[s]), e_alu[s], e_mem[s]}));
      if (s < n_ins) drive(s);
      else push = 1'b0;
    end
    push = 1'b0;
    @(negedge clk);
    chk(empty && !mem_fire && !alu_fire, "R9", "drained {empty,alu,mem}",
        int'({empty, alu_fire, mem_fire}), 4);
  endtask

  task automatic t_reset();
    @(negedge clk);
    rst_n = 1'b0; push = 1'b1; push_cls = 2'd1;
    push_dst = 5'd1; push_sa = 5'd2; push_sb = 5'd3;
    @(negedge clk);
    chk({empty, full, mem_fire, alu_fire, stall} == 5'b10000, "R1",
        "flags in reset", int'({empty, full, mem_fire, alu_fire, stall}), 16);
    chk(cyc_cnt == 0 && last_fire_cyc == 0, "R1", "counters in reset",
        int'(cyc_cnt) + int'(last_fire_cyc), 0);
    push = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk({empty, full, mem_fire, alu_fire, stall} == 5'b10000, "R1",
        "flags after release", int'({empty, full, mem_fire, alu_fire, stall}), 16);
  endtask

  // Ten-operation program with loads, stores and arithmetic interleaved.
  task automatic t_program();
    do_reset();
    set_ins(0, 2'd1, 5'd21, 5'd20, 5'd0);
    set_ins(1, 2'd1, 5'd18, 5'd17, 5'd0);
    set_ins(2, 2'd0, 5'd16, 5'd21, 5'd18);
    set_ins(3, 2'd1, 5'd15, 5'd14, 5'd0);
    set_ins(4, 2'd0, 5'd13, 5'd12, 5'd11);
    set_ins(5, 2'd0, 5'd23, 5'd22, 5'd24);
    set_ins(6, 2'd2, 5'd0,  5'd23, 5'd10);
    set_ins(7, 2'd0, 5'd4,  5'd21, 5'd18);
    set_ins(8, 2'd2, 5'd0,  5'd3,  5'd2);
    set_ins(9, 2'd2, 5'd0,  5'd1,  5'd4);
    clear_exp();
    e_mem[1] = 1; e_mem[2] = 1;
    e_mem[5] = 1; e_alu[5] = 1;
    e_alu[6] = 1; e_alu[7] = 1;
    e_mem[9] = 1; e_alu[9] = 1;
    e_mem[10] = 1; e_mem[11] = 1;
    run_prog(10, 11, "R2 R3 R4 R5 R6 R7 R8");
    chk(obs_cyc[11] - obs_cyc[1] == 16'd10, "R9", "cycle count span",
        int'(obs_cyc[11] - obs_cyc[1]), 10);
    chk(last_fire_cyc == obs_cyc[11], "R9", "last issue cycle",
        int'(last_fire_cyc), int'(obs_cyc[11]));
  endtask

  task automatic t_load_lat();
    do_reset();
    set_ins(0, 2'd1, 5'd7, 5'd1, 5'd0);
    set_ins(1, 2'd0, 5'd8, 5'd7, 5'd2);
    clear_exp();
    e_mem[1] = 1; e_alu[4] = 1;
    run_prog(2, 4, "R4");
  endtask

  task automatic t_alu_lat();
    do_reset();
    set_ins(0, 2'd0, 5'd5, 5'd1, 5'd2);
    set_ins(1, 2'd3, 5'd6, 5'd9, 5'd5);
    clear_exp();
    e_alu[1] = 1; e_alu[3] = 1;
    run_prog(2, 3, "R5");
  endtask

  // Younger store reads the older arithmetic result as its data.
  task automatic t_pair_raw();
    do_reset();
    set_ins(0, 2'd1, 5'd10, 5'd1,  5'd0);
    set_ins(1, 2'd0, 5'd11, 5'd10, 5'd10);
    set_ins(2, 2'd2, 5'd0,  5'd2,  5'd11);
    clear_exp();
    e_mem[1] = 1; e_alu[4] = 1; e_mem[6] = 1;
    run_prog(3, 6, "R6 R7");
  endtask

  task automatic t_load_ignores_b();
    do_reset();
    set_ins(0, 2'd1, 5'd20, 5'd1, 5'd0);
    set_ins(1, 2'd1, 5'd21, 5'd2, 5'd20);
    clear_exp();
    e_mem[1] = 1; e_mem[2] = 1;
    run_prog(2, 2, "R7");
  endtask

  task automatic t_store_no_dst();
    do_reset();
    set_ins(0, 2'd2, 5'd5, 5'd1, 5'd2);
    set_ins(1, 2'd0, 5'd6, 5'd5, 5'd5);
    clear_exp();
    e_mem[1] = 1; e_alu[2] = 1;
    run_prog(2, 2, "R7");
  endtask

  // Dependent chain fills a four-entry queue; the seventh push is dropped.
  task automatic t_full();
    do_reset();
    set_ins(0, 2'd1, 5'd1, 5'd0, 5'd0);
    set_ins(1, 2'd0, 5'd2, 5'd1, 5'd1);
    set_ins(2, 2'd0, 5'd3, 5'd2, 5'd2);
    set_ins(3, 2'd0, 5'd4, 5'd3, 5'd3);
    set_ins(4, 2'd0, 5'd5, 5'd4, 5'd4);
    set_ins(5, 2'd0, 5'd6, 5'd5, 5'd5);
    set_ins(6, 2'd2, 5'd0, 5'd0, 5'd0);
    clear_exp();
    e_mem[1] = 1; e_alu[4] = 1; e_alu[6] = 1;
    e_alu[8] = 1; e_alu[10] = 1; e_alu[12] = 1;
    run_prog(7, 12, "R10");
    chk(obs_full[5] == 1'b0, "R10", "full before last accepted push",
        int'(obs_full[5]), 0);
    chk(obs_full[6] == 1'b1, "R10", "full with DEPTH queued",
        int'(obs_full[6]), 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; push = 1'b0; push_cls = '0;
    push_dst = '0; push_sa = '0; push_sb = '0;
    t_reset();
    t_program();
    t_load_lat();
    t_alu_lat();
    t_pair_raw();
    t_load_ignores_b();
    t_store_no_dst();
    t_full();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule